// File: doc/BRIEF.md
# UART Receive/Transmit Automatic Flow Control

This block is the flow-control core of one UART channel. On the receive side it owns a 256-byte receive queue and its fill counter. From that fill level it drives an active-low request-to-send pin, `rts_n`. The pin uses hysteresis: it goes inactive when the queue climbs to a high-water mark. It becomes active again only once software has drained the queue down to a low-water mark. A receive interrupt is raised at a separate trigger level, and reception carries on into the queue after the interrupt fires.

On the transmit side the block synchronises the active-low clear-to-send input and decides, one character at a time, whether the next byte may be loaded into the shift register. A character that has already been loaded always runs to completion. Bit timing and the host bus lie outside the block and reach it through simple handshakes: `tx_load`, `tx_done` and `txq_ready`.

Two state machines carry the behaviour.

The RTS machine has the states `RTS_ON` and `RTS_OFF`:
- `RTS_ON` goes to `RTS_OFF` when the level reaches the high mark.
- `RTS_OFF` goes back to `RTS_ON` when the level drops to the low mark. With an invalid threshold pair it goes back when the level falls below the high mark.

The transmit gate has the states `TX_IDLE`, `TX_HOLD`, `TX_LOAD` and `TX_BUSY`:
- `TX_IDLE` goes to `TX_LOAD` when a byte is waiting and sending is allowed.
- `TX_IDLE` goes to `TX_HOLD` when a byte is waiting but sending is blocked.
- `TX_HOLD` goes to `TX_LOAD` once sending is allowed.
- `TX_HOLD` goes to `TX_IDLE` when no byte is waiting any more.
- `TX_LOAD` goes to `TX_BUSY` unconditionally.
- `TX_BUSY` goes to `TX_IDLE` on `tx_done`.

Top module: `uart_afc`

## Requirements
- R1: The receive queue returns bytes in arrival order on `rx_pop_data` (the head byte, shown ahead of the pop). `rx_level` counts the stored bytes. A push and a pop in the same cycle leave the level unchanged, and a pop on an empty queue does nothing.
- R2: A push while the queue holds 256 bytes, with no pop in the same cycle, is dropped. It leaves the level and the contents unchanged and sets `rx_overrun`. Only reset clears `rx_overrun`.
- R3: `rx_irq` is 1 in the cycle after `rx_level >= cfg_trig` holds, and is 0 in the cycle after the level is below the trigger.
- R4: With `cfg_auto_rts`=1, `rts_n` goes high one cycle after `rx_level` reaches `cfg_rts_hi`.
- R5: With a valid pair (`cfg_rts_lo < cfg_rts_hi <= 256`), `rts_n` stays high while the level is above `cfg_rts_lo`. It returns low one cycle after the level is at or below `cfg_rts_lo`.
- R6: With an invalid pair (`cfg_rts_hi <= cfg_rts_lo` or `cfg_rts_hi > 256`), `rts_n` is high exactly when the registered level is at or above `cfg_rts_hi`.
- R7: With `cfg_auto_rts`=0, `rts_n` equals the inverse of `cfg_rts_req` in the same cycle.
- R8: `cts_n` passes through a two-flop synchroniser. With `cfg_auto_cts`=1 and a synchronised `cts_n` high at a character boundary, no `tx_load` occurs and `tx_suspended` is 1.
- R9: When `cts_n` rises while a character is in the shift register, that character completes with `tx_done` and no further byte is loaded.
- R10: When `cts_n` returns low, loading resumes and every waiting byte is loaded, one `tx_load` pulse per byte.
- R11: With `cfg_auto_cts`=0, `cts_n` is ignored and waiting bytes are loaded.
- R12: After reset, `rx_level`=0, `rx_irq`=0, `rx_overrun`=0, `tx_load`=0, and `rts_n`=0 with auto-RTS enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Write a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Remove head byte |
| rx_pop_data | output | 8 | Head byte of receive queue |
| rx_level | output | 9 | Receive fill count |
| rx_irq | output | 1 | Receive trigger interrupt |
| rx_overrun | output | 1 | Sticky dropped-byte flag |
| cfg_trig | input | 9 | Interrupt trigger level |
| cfg_rts_hi | input | 9 | RTS high-water mark |
| cfg_rts_lo | input | 9 | RTS low-water mark |
| cfg_auto_rts | input | 1 | Enable automatic RTS |
| cfg_rts_req | input | 1 | Software RTS request when automatic RTS is off |
| rts_n | output | 1 | Request to send, active low |
| cfg_auto_cts | input | 1 | Enable automatic CTS gating |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| txq_ready | input | 1 | Transmit queue has a byte |
| tx_done | input | 1 | Shift register finished a character |
| tx_load | output | 1 | Load next byte into shift register |
| tx_suspended | output | 1 | Byte waiting but blocked by CTS |

## Verification
The RTS path is driven with a sequence of fill deltas. The sequence climbs through the trigger to the high mark, drains through the band between the two marks, and crosses the low mark twice. This separates true hysteresis from a plain threshold compare and from a design that keys RTS on the trigger level. A second pattern uses an inverted threshold pair, which shows whether the fallback to a single compare is taken. The transmit side is tried three ways: with CTS blocked before a byte arrives, with CTS dropped in the middle of a character, and with CTS gating disabled. Together these distinguish a gate that checks only at character boundaries from one that aborts the character or ignores the pin. A fill to 256 plus extra pushes checks that dropped bytes never corrupt the order of the bytes read back.

// File: rtl/afc_pkg.sv
package afc_pkg;
    typedef enum logic {
        RTS_ON,
        RTS_OFF
    } rts_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HOLD,
        TX_LOAD,
        TX_BUSY
    } tx_state_e;
endpackage

// File: rtl/afc_rx_fifo.sv
module afc_rx_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level,
    output logic          overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_pop, do_push, drop;

    assign do_pop  = pop && (level != '0);
    assign do_push = push && ((level != FULL) || do_pop);
    assign drop    = push && !do_push;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
            if (drop) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
    import afc_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] trig,
    input  logic [LW-1:0] hi,
    input  logic [LW-1:0] lo,
    input  logic          auto_rts,
    input  logic          rts_req,
    output logic          rts_n,
    output logic          irq
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    rts_state_e state_q, state_d;
    logic       pair_ok;

    assign pair_ok = (hi > lo) && (hi <= FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RTS_ON;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            irq     <= (level >= trig);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_ON:  if (level >= hi) state_d = RTS_OFF;
            RTS_OFF: begin
                if (pair_ok) begin
                    if (level <= lo) state_d = RTS_ON;
                end else if (level < hi) begin
                    state_d = RTS_ON;
                end
            end
            default: state_d = RTS_ON;
        endcase
    end

    always_comb begin
        if (auto_rts) rts_n = (state_q == RTS_OFF);
        else          rts_n = !rts_req;
    end
endmodule

// File: rtl/afc_cts_sync.sv
module afc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_n};
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate
    import afc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_sync_n,
    input  logic auto_cts,
    input  logic txq_ready,
    input  logic tx_done,
    output logic tx_load,
    output logic tx_suspended
);
    tx_state_e state_q, state_d;
    logic      go;

    assign go = !auto_cts || !cts_sync_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (txq_ready) state_d = go ? TX_LOAD : TX_HOLD;
            TX_HOLD: begin
                if (!txq_ready) state_d = TX_IDLE;
                else if (go)    state_d = TX_LOAD;
            end
            TX_LOAD: state_d = TX_BUSY;
            TX_BUSY: if (tx_done) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_load      = (state_q == TX_LOAD);
        tx_suspended = (state_q == TX_HOLD);
    end
endmodule

// File: rtl/uart_afc.sv
module uart_afc #(
    parameter int DEPTH       = 256,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LW          = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_pop_data,
    output logic [LW-1:0] rx_level,
    output logic          rx_irq,
    output logic          rx_overrun,
    input  logic [LW-1:0] cfg_trig,
    input  logic [LW-1:0] cfg_rts_hi,
    input  logic [LW-1:0] cfg_rts_lo,
    input  logic          cfg_auto_rts,
    input  logic          cfg_rts_req,
    output logic          rts_n,
    input  logic          cfg_auto_cts,
    input  logic          cts_n,
    input  logic          txq_ready,
    input  logic          tx_done,
    output logic          tx_load,
    output logic          tx_suspended
);
    logic cts_sync_n;

    afc_rx_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .pop_data(rx_pop_data),
        .level(rx_level), .overrun(rx_overrun)
    );

    afc_rts_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_rts (
        .clk(clk), .rst_n(rst_n), .level(rx_level),
        .trig(cfg_trig), .hi(cfg_rts_hi), .lo(cfg_rts_lo),
        .auto_rts(cfg_auto_rts), .rts_req(cfg_rts_req),
        .rts_n(rts_n), .irq(rx_irq)
    );

    afc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_n(cts_n), .sync_n(cts_sync_n)
    );

    afc_tx_gate u_tx (
        .clk(clk), .rst_n(rst_n), .cts_sync_n(cts_sync_n),
        .auto_cts(cfg_auto_cts), .txq_ready(txq_ready), .tx_done(tx_done),
        .tx_load(tx_load), .tx_suspended(tx_suspended)
    );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
    parameter int DEPTH = 256,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [LW-1:0] rx_level,
    input logic          rx_irq,
    input logic          rx_overrun,
    input logic [LW-1:0] cfg_trig,
    input logic [LW-1:0] cfg_rts_hi,
    input logic [LW-1:0] cfg_rts_lo,
    input logic          cfg_auto_rts,
    input logic          rts_n,
    input logic          tx_load,
    input logic          tx_suspended
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);
    logic pair_ok;
    assign pair_ok = (cfg_rts_hi > cfg_rts_lo) && (cfg_rts_hi <= FULL);

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= FULL);
    a_r1_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0 && !rx_push) |=> rx_level == '0);
    a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == FULL && rx_push && !rx_pop) |=> (rx_level == FULL && rx_overrun));
    a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(rx_level) >= $past(cfg_trig));
    a_r4_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && !rts_n && rx_level >= cfg_rts_hi) |=> (rts_n || !cfg_auto_rts));
    a_r5_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && pair_ok && rts_n && rx_level > cfg_rts_lo) |=> (rts_n || !cfg_auto_rts));
    a_r8_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (!tx_load && !tx_suspended));
endmodule

bind uart_afc afc_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_level(rx_level), .rx_irq(rx_irq), .rx_overrun(rx_overrun),
    .cfg_trig(cfg_trig), .cfg_rts_hi(cfg_rts_hi), .cfg_rts_lo(cfg_rts_lo),
    .cfg_auto_rts(cfg_auto_rts), .rts_n(rts_n),
    .tx_load(tx_load), .tx_suspended(tx_suspended)
);

// File: tb/uart_afc_tb.sv
`timescale 1ns/1ps
module uart_afc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_push_data = '0, rx_pop_data;
    logic [8:0] rx_level, cfg_trig, cfg_rts_hi, cfg_rts_lo;
    logic       rx_irq, rx_overrun, rts_n, tx_load, tx_suspended;
    logic       cfg_auto_rts = 1'b1, cfg_rts_req = 1'b0, cfg_auto_cts = 1'b1;
    logic       cts_n = 1'b1, txq_ready = 1'b0, tx_done = 1'b0;

    int total = 0, bad = 0;
    int mlevel = 0, wr_val = 0, rd_val = 0;
    int pend = 0, loads = 0, dones = 0, sh = 0;
    bit finished = 0;

    localparam int N = 12;
    localparam int DELTA [N] = '{7, 1, 3, 1, -2, -3, -2, -1, 3, 5, -8, -4};
    localparam bit EXP_RTS [N] = '{0, 0, 0, 1, 1, 1, 1, 0, 0, 1, 0, 0};
    localparam bit EXP_IRQ [N] = '{0, 1, 1, 1, 1, 0, 0, 0, 0, 1, 0, 0};

    always #5 clk = ~clk;

    uart_afc u_dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_level(rx_level),
        .rx_irq(rx_irq), .rx_overrun(rx_overrun), .cfg_trig(cfg_trig),
        .cfg_rts_hi(cfg_rts_hi), .cfg_rts_lo(cfg_rts_lo), .cfg_auto_rts(cfg_auto_rts),
        .cfg_rts_req(cfg_rts_req), .rts_n(rts_n), .cfg_auto_cts(cfg_auto_cts),
        .cts_n(cts_n), .txq_ready(txq_ready), .tx_done(tx_done),
        .tx_load(tx_load), .tx_suspended(tx_suspended)
    );

    // transmit shifter model: a loaded character takes four cycles
    always @(negedge clk) begin
        tx_done = 1'b0;
        if (tx_load) begin
            pend  = pend - 1;
            loads = loads + 1;
            sh    = 4;
        end else if (sh > 0) begin
            sh = sh - 1;
            if (sh == 0) begin
                tx_done = 1'b1;
                dones   = dones + 1;
            end
        end
        txq_ready = (pend > 0);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            rx_push = 1'b1;
            if (mlevel < 256) begin
                rx_push_data = 8'(wr_val);
                wr_val++;
                mlevel++;
            end else begin
                rx_push_data = 8'hEE;
            end
            @(negedge clk);
        end
        rx_push = 1'b0;
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            check(rx_pop_data == 8'(rd_val), "R1 order", rx_pop_data, rd_val & 255);
            rx_pop = 1'b1;
            rd_val++;
            mlevel--;
            @(negedge clk);
        end
        rx_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cfg_trig = 9'd8; cfg_rts_hi = 9'd12; cfg_rts_lo = 9'd4;
        idle(3);
        // R12 reset state
        check(rx_level == 0 && rx_irq == 0 && rx_overrun == 0, "R12 rx reset", rx_level, 0);
        check(rts_n == 0 && tx_load == 0, "R12 rts/tx reset", rts_n, 0);
        rst_n = 1'b1;
        idle(2);

        // vector table: R3 interrupt, R4/R5 hysteresis
        for (int v = 0; v < N; v++) begin
            if (DELTA[v] > 0) push_n(DELTA[v]);
            else              pop_n(-DELTA[v]);
            idle(3);
            check(rx_level == 9'(mlevel), "R1 level", rx_level, mlevel);
            check(rx_irq == EXP_IRQ[v], "R3 irq", rx_irq, EXP_IRQ[v]);
            check(rts_n == EXP_RTS[v], "R4/R5 rts", rts_n, EXP_RTS[v]);
        end

        // R2 overrun at full
        push_n(256);
        idle(2);
        check(rx_level == 256 && rx_overrun == 0, "R2 full no overrun", rx_level, 256);
        push_n(2);
        idle(2);
        check(rx_level == 256, "R2 dropped level", rx_level, 256);
        check(rx_overrun == 1, "R2 overrun set", rx_overrun, 1);
        // R1 simultaneous push and pop at full
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'(wr_val);
        check(rx_pop_data == 8'(rd_val), "R1 order", rx_pop_data, rd_val & 255);
        wr_val++; rd_val++;
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0;
        idle(1);
        check(rx_level == 256, "R1 push+pop level", rx_level, 256);
        pop_n(256);
        idle(2);
        check(rx_level == 0 && rx_overrun == 1, "R2 overrun sticky", rx_overrun, 1);
        // R1 pop on empty
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        idle(1);
        check(rx_level == 0, "R1 empty pop", rx_level, 0);

        // R6 invalid pair
        cfg_rts_hi = 9'd6; cfg_rts_lo = 9'd10;
        push_n(6);
        idle(3);
        check(rts_n == 1, "R6 rts at hi", rts_n, 1);
        pop_n(1);
        idle(3);
        check(rts_n == 0, "R6 rts below hi", rts_n, 0);
        pop_n(5);
        idle(2);

        // R7 software RTS
        cfg_auto_rts = 1'b0; cfg_rts_req = 1'b1; #1;
        check(rts_n == 0, "R7 sw request", rts_n, 0);
        cfg_rts_req = 1'b0; #1;
        check(rts_n == 1, "R7 sw release", rts_n, 1);
        cfg_auto_rts = 1'b1;
        idle(1);

        // R8 blocked by CTS
        pend = 3;
        idle(10);
        check(loads == 0, "R8 no load", loads, 0);
        check(tx_suspended == 1, "R8 suspended", tx_suspended, 1);
        // R10 resume
        cts_n = 1'b0;
        idle(40);
        check(loads == 3 && pend == 0, "R10 resumed loads", loads, 3);
        check(tx_suspended == 0, "R10 not suspended", tx_suspended, 0);

        // R9 drop mid-character
        pend = 2;
        wait (tx_load == 1'b1);
        @(negedge clk);
        cts_n = 1'b1;
        idle(30);
        check(loads == 4, "R9 one load only", loads, 4);
        check(dones == 4, "R9 char completed", dones, 4);
        check(tx_suspended == 1, "R9 suspended after", tx_suspended, 1);
        cts_n = 1'b0;
        idle(30);
        check(loads == 5 && pend == 0, "R10 second resume", loads, 5);

        // R11 CTS ignored
        cfg_auto_cts = 1'b0; cts_n = 1'b1; pend = 1;
        idle(20);
        check(loads == 6, "R11 cts ignored", loads, 6);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule